// File: doc/BRIEF.md
# Cluster Power-Gating Sequencer

This always-on controller sits in the SoC domain and drives the five control lines of one gated CPU cluster: the enable of the asynchronous bridge into the cluster, the cluster reset, the output isolation clamp, the cluster clock gate and the supply switch. Software starts a sequence by writing a power-up or power-down strobe. The sequencer then steps through a fixed order and holds each step for a programmable number of always-on clock cycles.

On the way up, the sequencer closes the switch and waits for a power-good acknowledge from it. It then opens the clock gate, drops the clamp, releases reset and finally enables the bridge. On the way down it runs the mirror order: bridge off, reset on, clamp on, then clock gate and switch off together. A timeout guards the acknowledge wait. A two-bit phase field and two sticky flags report progress and faults.

Whenever the supply is off, the clock is stopped, reset is held and the outputs are clamped. Each cluster gets its own instance, so clusters switch independently of each other.

Top module: `cluster_pwr_seq`

## Requirements
- R1: After synchronous reset, outputs are {bridge_en, cluster_rst, iso_en, clk_en, switch_en} = 0,1,1,0,0. The phase is 2'b00 and busy_flag and ack_err are 0.
- R2: After the acknowledge, power-up steps through three steps, each held for cfg_hold+1 cycles:
  - clock on (0,1,1,1,1);
  - isolation released (0,1,0,1,1);
  - reset released (0,0,0,1,1).
  Then it enters the on state (1,0,0,1,1) with phase 2'b11.
- R3: An accepted power-up request turns the switch on (0,1,1,0,1, phase 2'b01) on the next cycle. That state holds until pwr_good is sampled high. The clock turns on the cycle after that sample.
- R4: Suppose pwr_good is not sampled high on any of the cfg_ack_limit+1 edges after power-up starts. Then ack_err is set and the sequencer returns to the off outputs (0,1,1,0,0) with phase 2'b00.
- R5: An accepted power-down request runs four steps, each held for cfg_hold+1 cycles, with phase 2'b10:
  - bridge off (0,0,0,1,1);
  - reset asserted (0,1,0,1,1);
  - isolation on (0,1,1,1,1);
  - clock and switch off (0,1,1,0,0).
  It then returns to off with phase 2'b00.
- R6: Whenever switch_en is 0, iso_en and cluster_rst are 1 and clk_en is 0. The bridge is enabled only with the cluster fully up.
- R7: A request sampled while a sequence runs does not change the sequence and sets busy_flag. Both busy_flag and ack_err clear when a new sequence is accepted.
- R8: A power-down request while off, or a power-up request while on, changes no output, phase or flag.
- R9: If both strobes are sampled together, the power-down request wins.
- R10: The phase reads 2'b00 off, 2'b01 powering up, 2'b11 on and 2'b10 powering down.
- R11: cfg_hold and cfg_ack_limit are captured when a sequence is accepted. Changing them during the sequence has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| req_up | input | 1 | Power-up request strobe |
| req_down | input | 1 | Power-down request strobe |
| cfg_hold | input | HOLD_W | Extra hold cycles per step |
| cfg_ack_limit | input | LIM_W | Acknowledge timeout limit |
| pwr_good | input | 1 | Supply switch power-good acknowledge |
| bridge_en | output | 1 | Asynchronous bridge enable |
| cluster_rst | output | 1 | Cluster reset, active high |
| iso_en | output | 1 | Output isolation clamp enable |
| clk_en | output | 1 | Cluster clock gate enable |
| switch_en | output | 1 | Supply switch enable |
| phase | output | 2 | Current phase code |
| busy_flag | output | 1 | Sticky: a request arrived mid-sequence |
| ack_err | output | 1 | Sticky: acknowledge timed out |

## Verification
The properties assume that pwr_good only matters while the switch is on and the sequencer is waiting. They also assume that request strobes are plain one-cycle levels sampled on the clock. The stimulus raises pwr_good only after a power-up has begun and drops it once the cluster is back off. Mid-sequence requests are injected only on cycles where the bench has just observed a transit phase. Acknowledge delays are drawn on both sides of the timeout limit, so success and timeout both occur.

// File: rtl/cps_pkg.sv
package cps_pkg;

    typedef enum logic [3:0] {
        S_OFF,
        S_UP_SW,
        S_UP_CLK,
        S_UP_ISO,
        S_UP_RST,
        S_ON,
        S_DN_BRG,
        S_DN_RST,
        S_DN_ISO,
        S_DN_SW
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_OFF     = 2'b00,
        PH_RISING  = 2'b01,
        PH_FALLING = 2'b10,
        PH_ON      = 2'b11
    } phase_e;

    typedef enum logic [1:0] {
        REQ_NONE,
        REQ_START_UP,
        REQ_START_DOWN,
        REQ_REJECT
    } req_kind_e;

    typedef struct packed {
        logic bridge;
        logic rst;
        logic iso;
        logic clk;
        logic sw;
    } gate_ctl_t;

    function automatic gate_ctl_t gate_ctl_of(seq_state_e s);
        gate_ctl_t c;
        case (s)
            S_UP_SW:  c = '{bridge: 1'b0, rst: 1'b1, iso: 1'b1, clk: 1'b0, sw: 1'b1};
            S_UP_CLK: c = '{bridge: 1'b0, rst: 1'b1, iso: 1'b1, clk: 1'b1, sw: 1'b1};
            S_UP_ISO: c = '{bridge: 1'b0, rst: 1'b1, iso: 1'b0, clk: 1'b1, sw: 1'b1};
            S_UP_RST: c = '{bridge: 1'b0, rst: 1'b0, iso: 1'b0, clk: 1'b1, sw: 1'b1};
            S_ON:     c = '{bridge: 1'b1, rst: 1'b0, iso: 1'b0, clk: 1'b1, sw: 1'b1};
            S_DN_BRG: c = '{bridge: 1'b0, rst: 1'b0, iso: 1'b0, clk: 1'b1, sw: 1'b1};
            S_DN_RST: c = '{bridge: 1'b0, rst: 1'b1, iso: 1'b0, clk: 1'b1, sw: 1'b1};
            S_DN_ISO: c = '{bridge: 1'b0, rst: 1'b1, iso: 1'b1, clk: 1'b1, sw: 1'b1};
            default:  c = '{bridge: 1'b0, rst: 1'b1, iso: 1'b1, clk: 1'b0, sw: 1'b0};
        endcase
        return c;
    endfunction

    function automatic phase_e phase_of(seq_state_e s);
        phase_e p;
        case (s)
            S_OFF:                                  p = PH_OFF;
            S_ON:                                   p = PH_ON;
            S_UP_SW, S_UP_CLK, S_UP_ISO, S_UP_RST:  p = PH_RISING;
            default:                                p = PH_FALLING;
        endcase
        return p;
    endfunction

    function automatic logic in_transit(seq_state_e s);
        return (s != S_OFF) && (s != S_ON);
    endfunction

    function automatic seq_state_e step_after(seq_state_e s);
        seq_state_e n;
        case (s)
            S_UP_CLK: n = S_UP_ISO;
            S_UP_ISO: n = S_UP_RST;
            S_UP_RST: n = S_ON;
            S_DN_BRG: n = S_DN_RST;
            S_DN_RST: n = S_DN_ISO;
            S_DN_ISO: n = S_DN_SW;
            default:  n = S_OFF;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/cps_req_decode.sv
module cps_req_decode
    import cps_pkg::*;
(
    input  seq_state_e state,
    input  logic       req_up,
    input  logic       req_down,
    output req_kind_e  kind
);
    always_comb begin
        kind = REQ_NONE;
        if (req_down) begin
            if (in_transit(state))
                kind = REQ_REJECT;
            else if (state == S_ON)
                kind = REQ_START_DOWN;
        end else if (req_up) begin
            if (in_transit(state))
                kind = REQ_REJECT;
            else if (state == S_OFF)
                kind = REQ_START_UP;
        end
    end
endmodule

// File: rtl/cps_step_timer.sv
module cps_step_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (ld)
            cnt <= ld_val;
        else if (inc)
            cnt <= cnt + 1'b1;
        else if (dec)
            cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/cps_seq_ctrl.sv
module cps_seq_ctrl
    import cps_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  req_kind_e        kind,
    input  logic             pwr_good,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] hold_start,
    input  logic [CNT_W-1:0] hold_run,
    input  logic [CNT_W-1:0] lim_run,
    output seq_state_e       state_q,
    output seq_state_e       state_d,
    output logic             ld,
    output logic [CNT_W-1:0] ld_val,
    output logic             inc,
    output logic             dec,
    output logic             err_set
);
    always_comb begin
        state_d = state_q;
        ld      = 1'b0;
        ld_val  = '0;
        inc     = 1'b0;
        dec     = 1'b0;
        err_set = 1'b0;
        case (state_q)
            S_OFF: begin
                if (kind == REQ_START_UP) begin
                    state_d = S_UP_SW;
                    ld      = 1'b1;
                    ld_val  = '0;
                end
            end
            S_ON: begin
                if (kind == REQ_START_DOWN) begin
                    state_d = S_DN_BRG;
                    ld      = 1'b1;
                    ld_val  = hold_start;
                end
            end
            S_UP_SW: begin
                if (pwr_good) begin
                    state_d = S_UP_CLK;
                    ld      = 1'b1;
                    ld_val  = hold_run;
                end else if (cnt == lim_run) begin
                    state_d = S_OFF;
                    err_set = 1'b1;
                end else begin
                    inc = 1'b1;
                end
            end
            default: begin
                if (cnt == '0) begin
                    state_d = step_after(state_q);
                    ld      = 1'b1;
                    ld_val  = hold_run;
                end else begin
                    dec = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= S_OFF;
        else
            state_q <= state_d;
    end
endmodule

// File: rtl/cluster_pwr_seq.sv
module cluster_pwr_seq
    import cps_pkg::*;
#(
    parameter int HOLD_W = 8,
    parameter int LIM_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_up,
    input  logic              req_down,
    input  logic [HOLD_W-1:0] cfg_hold,
    input  logic [LIM_W-1:0]  cfg_ack_limit,
    input  logic              pwr_good,
    output logic              bridge_en,
    output logic              cluster_rst,
    output logic              iso_en,
    output logic              clk_en,
    output logic              switch_en,
    output logic [1:0]        phase,
    output logic              busy_flag,
    output logic              ack_err
);
    localparam int CNT_W = (HOLD_W > LIM_W) ? HOLD_W : LIM_W;

    seq_state_e       state_q;
    seq_state_e       state_d;
    req_kind_e        kind;
    logic             accept;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] hold_start;
    logic [CNT_W-1:0] hold_q;
    logic [CNT_W-1:0] lim_q;
    logic             ld;
    logic [CNT_W-1:0] ld_val;
    logic             inc;
    logic             dec;
    logic             err_set;
    gate_ctl_t        ctl_q;
    phase_e           phase_q;

    assign hold_start = CNT_W'(cfg_hold);
    assign accept     = (kind == REQ_START_UP) || (kind == REQ_START_DOWN);

    cps_req_decode u_decode (
        .state    (state_q),
        .req_up   (req_up),
        .req_down (req_down),
        .kind     (kind)
    );

    cps_step_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .ld     (ld),
        .ld_val (ld_val),
        .inc    (inc),
        .dec    (dec),
        .cnt    (cnt)
    );

    cps_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .kind       (kind),
        .pwr_good   (pwr_good),
        .cnt        (cnt),
        .hold_start (hold_start),
        .hold_run   (hold_q),
        .lim_run    (lim_q),
        .state_q    (state_q),
        .state_d    (state_d),
        .ld         (ld),
        .ld_val     (ld_val),
        .inc        (inc),
        .dec        (dec),
        .err_set    (err_set)
    );

    // configuration snapshot taken when a sequence is accepted
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            lim_q  <= '0;
        end else if (accept) begin
            hold_q <= hold_start;
            lim_q  <= CNT_W'(cfg_ack_limit);
        end
    end

    // registered control lines and status
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q     <= gate_ctl_of(S_OFF);
            phase_q   <= PH_OFF;
            busy_flag <= 1'b0;
            ack_err   <= 1'b0;
        end else begin
            ctl_q   <= gate_ctl_of(state_d);
            phase_q <= phase_of(state_d);
            if (accept)
                busy_flag <= 1'b0;
            else if (kind == REQ_REJECT)
                busy_flag <= 1'b1;
            if (accept)
                ack_err <= 1'b0;
            else if (err_set)
                ack_err <= 1'b1;
        end
    end

    assign bridge_en   = ctl_q.bridge;
    assign cluster_rst = ctl_q.rst;
    assign iso_en      = ctl_q.iso;
    assign clk_en      = ctl_q.clk;
    assign switch_en   = ctl_q.sw;
    assign phase       = phase_q;
endmodule

// File: rtl/cps_checker.sv
module cps_checker (
    input logic       clk,
    input logic       rst,
    input logic       req_up,
    input logic       req_down,
    input logic       pwr_good,
    input logic       bridge_en,
    input logic       cluster_rst,
    input logic       iso_en,
    input logic       clk_en,
    input logic       switch_en,
    input logic [1:0] phase,
    input logic       busy_flag,
    input logic       ack_err
);
    assert_gated_safe_R6: assert property (@(posedge clk) disable iff (rst)
        !switch_en |-> (iso_en && cluster_rst && !clk_en));

    assert_bridge_full_up_R6: assert property (@(posedge clk) disable iff (rst)
        bridge_en |-> (!cluster_rst && !iso_en && clk_en && switch_en));

    assert_clk_after_ack_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_en) |-> $past(pwr_good));

    assert_rst_release_order_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(cluster_rst) |-> ($past(!iso_en) && clk_en));

    assert_switch_off_order_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(switch_en) |-> ($past(iso_en) && $past(cluster_rst) && $past(!bridge_en)));

    assert_timeout_to_off_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_err) |-> (phase == 2'b00 && !switch_en));

    assert_busy_flagged_R7: assert property (@(posedge clk) disable iff (rst)
        ((phase == 2'b01 || phase == 2'b10) && (req_up || req_down)) |=> busy_flag);

    assert_noop_off_R8: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'b00 && req_down) |=> (phase == 2'b00 && $stable(ack_err) && $stable(busy_flag)));

    assert_noop_on_R8: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'b11 && req_up && !req_down) |=> (phase == 2'b11 && bridge_en));

    assert_down_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'b11 && req_down) |=> (phase == 2'b10));
endmodule

bind cluster_pwr_seq cps_checker u_cps_checker (
    .clk         (clk),
    .rst         (rst),
    .req_up      (req_up),
    .req_down    (req_down),
    .pwr_good    (pwr_good),
    .bridge_en   (bridge_en),
    .cluster_rst (cluster_rst),
    .iso_en      (iso_en),
    .clk_en      (clk_en),
    .switch_en   (switch_en),
    .phase       (phase),
    .busy_flag   (busy_flag),
    .ack_err     (ack_err)
);

// File: tb/test_cluster_pwr_seq.sv
`timescale 1ns/1ps
module test_cluster_pwr_seq;
    localparam int HOLD_W = 8;
    localparam int LIM_W  = 10;

    // expected {bridge, rst, iso, clk, sw} per step, from the requirements
    localparam logic [4:0] V_OFF   = 5'b01100;
    localparam logic [4:0] V_UPSW  = 5'b01101;
    localparam logic [4:0] V_UPCLK = 5'b01111;
    localparam logic [4:0] V_UPISO = 5'b01011;
    localparam logic [4:0] V_UPRST = 5'b00011;
    localparam logic [4:0] V_ON    = 5'b10011;
    localparam logic [4:0] V_DNBRG = 5'b00011;
    localparam logic [4:0] V_DNRST = 5'b01011;
    localparam logic [4:0] V_DNISO = 5'b01111;
    localparam logic [4:0] V_DNSW  = 5'b01100;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_up = 1'b0;
    logic              req_down = 1'b0;
    logic [HOLD_W-1:0] cfg_hold = '0;
    logic [LIM_W-1:0]  cfg_ack_limit = '0;
    logic              pwr_good = 1'b0;
    logic              bridge_en, cluster_rst, iso_en, clk_en, switch_en;
    logic [1:0]        phase;
    logic              busy_flag, ack_err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int inj_cnt = 0;
    int inj_at = -1;
    bit inj_down = 1'b0;
    bit injected = 1'b0;
    bit is_on = 1'b0;

    always #2.5 clk = ~clk;

    cluster_pwr_seq #(.HOLD_W(HOLD_W), .LIM_W(LIM_W)) i_cluster_pwr_seq (
        .clk           (clk),
        .rst           (rst),
        .req_up        (req_up),
        .req_down      (req_down),
        .cfg_hold      (cfg_hold),
        .cfg_ack_limit (cfg_ack_limit),
        .pwr_good      (pwr_good),
        .bridge_en     (bridge_en),
        .cluster_rst   (cluster_rst),
        .iso_en        (iso_en),
        .clk_en        (clk_en),
        .switch_en     (switch_en),
        .phase         (phase),
        .busy_flag     (busy_flag),
        .ack_err       (ack_err)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: cycles %0d expected below %0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic step_tick();
        if (inj_cnt == inj_at) begin
            if (inj_down) req_down = 1'b1;
            else          req_up   = 1'b1;
            injected = 1'b1;
        end
        tick();
        req_up   = 1'b0;
        req_down = 1'b0;
        inj_cnt++;
    endtask

    task automatic check_state(string req, logic [4:0] ev, logic [1:0] ep);
        logic [4:0] av;
        av = {bridge_en, cluster_rst, iso_en, clk_en, switch_en};
        checks++;
        if (av !== ev || phase !== ep) begin
            errors++;
            $display("FAIL %s: outputs %b phase %b, expected outputs %b phase %b",
                     req, av, phase, ev, ep);
        end
    endtask

    task automatic check_flags(string req, logic eb, logic ee);
        checks++;
        if (busy_flag !== eb || ack_err !== ee) begin
            errors++;
            $display("FAIL %s: busy %b err %b, expected busy %b err %b",
                     req, busy_flag, ack_err, eb, ee);
        end
    endtask

    task automatic hold_step(string req, logic [4:0] ev, logic [1:0] ep, int hold);
        for (int k = 0; k <= hold; k++) begin
            check_state(req, ev, ep);
            step_tick();
        end
    endtask

    // R3/R2/R4/R11: power-up with a chosen acknowledge delay
    task automatic run_up(int hold, int lim, int delay, bit alter_cfg, int inj);
        int nsw;
        cfg_hold      = HOLD_W'(hold);
        cfg_ack_limit = LIM_W'(lim);
        req_up        = 1'b1;
        tick();
        req_up = 1'b0;
        if (alter_cfg) begin
            cfg_hold      = HOLD_W'(hold + 3);
            cfg_ack_limit = LIM_W'(lim + 4);
        end
        check_flags("R7 flags cleared on accepted power-up", 1'b0, 1'b0);
        inj_cnt  = 0;
        inj_at   = inj;
        injected = 1'b0;
        nsw = (delay <= lim + 1) ? delay : lim + 1;
        for (int j = 1; j <= nsw; j++) begin
            check_state("R3 switch on, waiting for ack", V_UPSW, 2'b01);
            if (j == delay) pwr_good = 1'b1;
            step_tick();
        end
        if (delay <= lim + 1) begin
            hold_step("R2 clock step (R11 captured hold)", V_UPCLK, 2'b01, hold);
            hold_step("R2 isolation release step", V_UPISO, 2'b01, hold);
            hold_step("R2 reset release step", V_UPRST, 2'b01, hold);
            check_state("R2 on state R10", V_ON, 2'b11);
            check_flags("R7 busy after mid-sequence request", injected, 1'b0);
            is_on = 1'b1;
        end else begin
            check_state("R4 timeout back to off", V_OFF, 2'b00);
            check_flags("R4 ack_err after timeout", injected, 1'b1);
            is_on = 1'b0;
        end
        inj_at = -1;
    endtask

    // R5/R9/R11: power-down
    task automatic run_down(int hold, bit both, bit alter_cfg, int inj);
        cfg_hold = HOLD_W'(hold);
        req_down = 1'b1;
        req_up   = both;
        tick();
        req_down = 1'b0;
        req_up   = 1'b0;
        if (alter_cfg) cfg_hold = HOLD_W'(hold + 2);
        check_flags("R7 flags cleared on accepted power-down", 1'b0, 1'b0);
        inj_cnt  = 0;
        inj_at   = inj;
        injected = 1'b0;
        hold_step(both ? "R9 down wins, bridge off step" : "R5 bridge off step", V_DNBRG, 2'b10, hold);
        hold_step("R5 reset assert step", V_DNRST, 2'b10, hold);
        hold_step("R5 isolation step", V_DNISO, 2'b10, hold);
        hold_step("R5 clock and switch off step R6", V_DNSW, 2'b10, hold);
        check_state("R5 off state R10", V_OFF, 2'b00);
        check_flags("R7 busy after mid-sequence request", injected, 1'b0);
        pwr_good = 1'b0;
        is_on    = 1'b0;
        inj_at   = -1;
    endtask

    // R8/R9: a request that should change nothing
    task automatic run_noop(bit both);
        logic b0, e0;
        logic [4:0] v;
        logic [1:0] p;
        b0 = busy_flag;
        e0 = ack_err;
        v  = is_on ? V_ON : V_OFF;
        p  = is_on ? 2'b11 : 2'b00;
        if (is_on) req_up = 1'b1;
        else begin
            req_down = 1'b1;
            req_up   = both;
        end
        tick();
        req_up   = 1'b0;
        req_down = 1'b0;
        check_state(both ? "R9 both strobes while off" : "R8 redundant request", v, p);
        check_flags("R8 flags untouched", b0, e0);
        tick();
        check_state("R8 still settled", v, p);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        check_state("R1 outputs in reset", V_OFF, 2'b00);
        rst = 1'b0;
        tick();
        check_state("R1 reset state R10", V_OFF, 2'b00);
        check_flags("R1 reset flags", 1'b0, 1'b0);

        // directed corner cases
        run_noop(1'b0);
        run_up(0, 0, 1, 1'b0, -1);
        run_noop(1'b0);
        run_down(0, 1'b0, 1'b0, -1);
        run_up(2, 3, 4, 1'b0, 1);
        run_down(1, 1'b1, 1'b0, 2);
        run_up(1, 2, 4, 1'b0, -1);
        run_noop(1'b1);
        run_up(1, 1, 1, 1'b0, 0);
        run_down(2, 1'b0, 1'b1, -1);
        run_up(3, 2, 2, 1'b1, -1);
        run_noop(1'b0);
        run_down(0, 1'b0, 1'b0, 0);

        // constrained random
        for (int n = 0; n < 60; n++) begin
            int hold, lim, delay, inj;
            hold     = int'($urandom % 5);
            lim      = int'($urandom % 6);
            delay    = 1 + int'($urandom % (lim + 3));
            inj      = ($urandom % 3 == 0) ? int'($urandom % 8) : -1;
            inj_down = ($urandom % 2) == 1;
            if ($urandom % 5 == 0)
                run_noop(($urandom % 2) == 1);
            else if (is_on)
                run_down(hold, ($urandom % 4) == 0, ($urandom % 3) == 0, inj);
            else
                run_up(hold, lim, delay, ($urandom % 3) == 0, inj);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule